// File: doc/BRIEF.md
# Deferred-Poison SECDED Word Store

This block is a small word-addressed storage array. Each stored word carries single-error-correct, double-error-detect check bits. Reads that find one flipped bit return the corrected word and write the repaired codeword back during the same access. An uncorrectable error does not stop the system. The block instead rewrites the word's check bits with a poison marker. Normal ECC decoding can never produce that marker, so it stays apart from any genuine single- or double-bit fault.

The detecting access gets zero data with a poison flag. It also causes a one-cycle notification toward a service controller. An error is raised only when a later read actually consumes the poisoned word. A read tagged as ordinary (`req_priv`=0) gets an error confined to that requester. A read tagged as privileged (`req_priv`=1) gets a system-fatal error.

A write with every byte lane enabled discards the old contents and silently clears any poison. A write with only some byte lanes enabled leaves the other bytes unknown, so it keeps the poison.

A test input flips chosen codeword bits as a write is stored, so faults can be created at the ports.

Top module: `poison_word_store`

## Requirements
- R1: A read request accepted at a rising edge returns `rsp_valid`=1 with the stored word on `rsp_rdata` right after that edge. A write produces no response. The privilege bit has no effect on a clean word.
- R2: A word holding exactly one flipped codeword bit is returned corrected and the repaired codeword is stored back. The flipped bit may be a data bit, a check bit or the overall parity bit (`inj_flip` bit i below DATA_W flips data bit i, the bits above flip check bits, and the top bit flips overall parity). Later reads keep returning the correct word.
- R3: A read that finds a two-bit error returns zero data with `rsp_poison`=1 and raises neither error output. It stores the poison marker in the check bits: every Hamming check bit inverted, plus the overall bit when needed to make the total inversion count odd.
- R4: `svc_pulse` is high for exactly one cycle each time a word newly becomes poisoned. It is never high on a read of a word that is already poisoned.
- R5: A read with `req_priv`=0 of a poisoned word returns zero data with `rsp_poison`=1 and `err_recov`=1 for one cycle, with `err_addr` holding the address. `err_fatal` stays 0.
- R6: A read with `req_priv`=1 of a poisoned word raises `err_fatal` for one cycle, with `err_addr` set. `err_recov` stays 0.
- R7: A write with all `req_be` bits set to a poisoned word clears the poison without raising any error or pulse. A later read returns the new data cleanly.
- R8: A partial write (some `req_be` bit clear) to a poisoned word keeps it poisoned, with no pulse. A partial write to a word with an undetected two-bit error poisons it and raises `svc_pulse`.
- R9: A partial write replaces byte b (bits 8b+7..8b) where `req_be[b]`=1 and keeps the corrected old content in the other bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | $clog2(DEPTH) | Word address |
| req_be | input | DATA_W/8 | Byte lane enables for writes |
| req_wdata | input | DATA_W | Write data |
| req_priv | input | 1 | Read requester is privileged |
| inj_flip | input | DATA_W+P+1 | Codeword bits to flip as a write is stored |
| rsp_valid | output | 1 | Read response present |
| rsp_rdata | output | DATA_W | Read data, zero when poisoned |
| rsp_poison | output | 1 | Response carries poisoned data |
| err_recov | output | 1 | Requester-scoped error pulse |
| err_fatal | output | 1 | System-fatal error pulse |
| err_addr | output | $clog2(DEPTH) | Address of the last consumed poisoned word |
| svc_pulse | output | 1 | New poisoning notification |

## Verification
The bench drives clean words with both privilege values. It then drives single flips placed in a data bit, a Hamming check bit and the overall parity bit, which shows whether correction depends on where the fault sits. Two-bit faults are read first and then read again by each privilege class, which separates silent detection from consumption and the recoverable error from the fatal one. Full and partial overwrites of poisoned, double-faulted and single-faulted words tell clearing apart from retention and check the byte merge against corrected data. Two double-faulted words read back to back show that each pulse belongs to its own poisoning.

// File: rtl/poison_pkg.sv
package poison_pkg;

   typedef enum logic [1:0] {
      EK_CLEAN  = 2'd0,
      EK_SINGLE = 2'd1,
      EK_MULTI  = 2'd2,
      EK_POISON = 2'd3
   } ecc_kind_e;

   // Number of Hamming check bits for a given data width.
   function automatic int unsigned hamming_bits(input int unsigned dw);
      int unsigned p;
      p = 1;
      while ((32'd1 << p) < dw + p + 1) p++;
      return p;
   endfunction

   // Codeword position (1-based) of data bit i: i-th non-power-of-two from 3.
   function automatic int unsigned data_pos(input int unsigned i);
      int unsigned r;
      int unsigned cnt;
      r = 0;
      cnt = 0;
      for (int unsigned q = 3; q < 1024; q++) begin
         if (r == 0 && (q & (q - 1)) != 0) begin
            if (cnt == i) r = q;
            cnt++;
         end
      end
      return r;
   endfunction

endpackage

// File: rtl/secded_enc.sv
module secded_enc import poison_pkg::*; #(
   parameter int unsigned DATA_W = 32
) (
   input  logic [DATA_W-1:0]                 data_i,
   output logic [hamming_bits(DATA_W):0]     chk_o
);
   localparam int unsigned P = hamming_bits(DATA_W);

   for (genvar j = 0; j < P; j++) begin : g_col
      logic [DATA_W-1:0] taps;
      for (genvar i = 0; i < DATA_W; i++) begin : g_bit
         localparam int unsigned POS = data_pos(i);
         if (((POS >> j) & 1) != 0) begin : g_on
            assign taps[i] = data_i[i];
         end else begin : g_off
            assign taps[i] = 1'b0;
         end
      end
      assign chk_o[j] = ^taps;
   end

   assign chk_o[P] = (^data_i) ^ (^chk_o[P-1:0]);
endmodule

// File: rtl/secded_dec.sv
module secded_dec import poison_pkg::*; #(
   parameter int unsigned DATA_W = 32
) (
   input  logic [DATA_W-1:0]             data_i,
   input  logic [hamming_bits(DATA_W):0] chk_i,
   output ecc_kind_e                     kind_o,
   output logic [DATA_W-1:0]             data_o
);
   localparam int unsigned P = hamming_bits(DATA_W);
   localparam int unsigned LAST_POS = DATA_W + P;

   logic [P:0]        recalc;
   logic [P-1:0]      syn;
   logic              par;
   logic [DATA_W-1:0] fix;

   secded_enc #(.DATA_W(DATA_W)) u_enc (.data_i(data_i), .chk_o(recalc));

   assign syn = recalc[P-1:0] ^ chk_i[P-1:0];
   assign par = (^data_i) ^ (^chk_i);

   for (genvar i = 0; i < DATA_W; i++) begin : g_fix
      localparam int unsigned POS = data_pos(i);
      localparam logic [P-1:0] POSV = POS[P-1:0];
      assign fix[i] = par && (syn == POSV);
   end

   always_comb begin
      if (par && (&syn))                         kind_o = EK_POISON;
      else if (par && (32'(syn) <= LAST_POS))    kind_o = EK_SINGLE;
      else if (par)                              kind_o = EK_MULTI;
      else if (syn != '0)                        kind_o = EK_MULTI;
      else                                       kind_o = EK_CLEAN;
   end

   assign data_o = data_i ^ ((kind_o == EK_SINGLE) ? fix : '0);
endmodule

// File: rtl/word_array.sv
module word_array #(
   parameter int unsigned WIDTH = 39,
   parameter int unsigned DEPTH = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [$clog2(DEPTH)-1:0] addr,
   input  logic [WIDTH-1:0]         wdata,
   output logic [WIDTH-1:0]         rdata
);
   logic [WIDTH-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
      end else if (we) begin
         mem[addr] <= wdata;
      end
   end

   assign rdata = mem[addr];
endmodule

// File: rtl/poison_word_store.sv
module poison_word_store import poison_pkg::*; #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DEPTH  = 16
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               req_valid,
   input  logic                               req_write,
   input  logic [$clog2(DEPTH)-1:0]           req_addr,
   input  logic [DATA_W/8-1:0]                req_be,
   input  logic [DATA_W-1:0]                  req_wdata,
   input  logic                               req_priv,
   input  logic [DATA_W+hamming_bits(DATA_W):0] inj_flip,
   output logic                               rsp_valid,
   output logic [DATA_W-1:0]                  rsp_rdata,
   output logic                               rsp_poison,
   output logic                               err_recov,
   output logic                               err_fatal,
   output logic [$clog2(DEPTH)-1:0]           err_addr,
   output logic                               svc_pulse
);
   localparam int unsigned P     = hamming_bits(DATA_W);
   localparam int unsigned CHK_W = P + 1;
   localparam int unsigned CW    = DATA_W + CHK_W;
   localparam int unsigned NB    = DATA_W / 8;
   localparam logic [CHK_W-1:0] POISON_MASK = {((P % 2) == 0), {P{1'b1}}};

   // elaboration checks
   if (DATA_W < 8 || (DATA_W % 8) != 0) begin : g_bad_width
      $error("DATA_W must be a nonzero multiple of 8");
   end
   if (((32'd1 << P) - 1) <= DATA_W + P) begin : g_bad_marker
      $error("all-ones syndrome collides with a codeword position");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be at least 2");
   end

   logic [CW-1:0]     rd_cw;
   logic [CW-1:0]     wr_cw;
   ecc_kind_e         kind;
   logic [DATA_W-1:0] fixed;
   logic [DATA_W-1:0] merged;
   logic [DATA_W-1:0] wr_data;
   logic [CHK_W-1:0]  wr_chk;
   logic              wr_en;
   logic              poison_keep;
   logic              poison_new;
   logic              rd_req;
   logic              full;

   word_array #(.WIDTH(CW), .DEPTH(DEPTH)) u_array (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_en),
      .addr  (req_addr),
      .wdata (wr_cw),
      .rdata (rd_cw)
   );

   secded_dec #(.DATA_W(DATA_W)) u_dec (
      .data_i (rd_cw[DATA_W-1:0]),
      .chk_i  (rd_cw[CW-1:DATA_W]),
      .kind_o (kind),
      .data_o (fixed)
   );

   for (genvar b = 0; b < NB; b++) begin : g_lane
      assign merged[8*b +: 8] = req_be[b] ? req_wdata[8*b +: 8] : fixed[8*b +: 8];
   end

   assign rd_req = req_valid && !req_write;
   assign full   = &req_be;

   always_comb begin
      wr_en       = 1'b0;
      wr_data     = merged;
      poison_keep = 1'b0;
      poison_new  = 1'b0;
      if (req_valid && req_write) begin
         wr_en = 1'b1;
         if (!full && kind == EK_MULTI) begin
            poison_keep = 1'b1;
            poison_new  = 1'b1;
         end else if (!full && kind == EK_POISON) begin
            poison_keep = 1'b1;
         end
      end else if (rd_req) begin
         if (kind == EK_SINGLE) begin
            wr_en   = 1'b1;
            wr_data = fixed;
         end else if (kind == EK_MULTI) begin
            wr_en       = 1'b1;
            wr_data     = rd_cw[DATA_W-1:0];
            poison_keep = 1'b1;
            poison_new  = 1'b1;
         end
      end
   end

   secded_enc #(.DATA_W(DATA_W)) u_enc (.data_i(wr_data), .chk_o(wr_chk));

   assign wr_cw = {wr_chk ^ (poison_keep ? POISON_MASK : '0), wr_data}
                ^ ((req_valid && req_write) ? inj_flip : '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_rdata  <= '0;
         rsp_poison <= 1'b0;
         err_recov  <= 1'b0;
         err_fatal  <= 1'b0;
         err_addr   <= '0;
         svc_pulse  <= 1'b0;
      end else begin
         rsp_valid  <= rd_req;
         rsp_poison <= rd_req && (kind == EK_MULTI || kind == EK_POISON);
         rsp_rdata  <= (rd_req && (kind == EK_CLEAN || kind == EK_SINGLE)) ? fixed : '0;
         err_recov  <= rd_req && kind == EK_POISON && !req_priv;
         err_fatal  <= rd_req && kind == EK_POISON && req_priv;
         if (rd_req && kind == EK_POISON) err_addr <= req_addr;
         svc_pulse  <= poison_new;
      end
   end

   // R1: writes never produce a response
   assert_no_rsp_on_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write) |=> !rsp_valid);
   // R3: poisoned responses carry no data
   assert_poison_zero_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_poison |-> (rsp_rdata == '0 && rsp_valid));
   // R4: a poisoned response without an error is a fresh detection and notifies
   assert_fresh_detect_notifies_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_poison && !err_recov && !err_fatal) |-> svc_pulse);
   // R4: consuming an already-poisoned word never notifies
   assert_consume_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (err_recov || err_fatal) |-> !svc_pulse);
   // R5: scoped error only for ordinary requesters
   assert_recov_unpriv_R5: assert property (@(posedge clk) disable iff (!rst_n)
      err_recov |-> (!$past(req_priv) && rsp_poison && !err_fatal));
   // R6: fatal error only for privileged requesters
   assert_fatal_priv_R6: assert property (@(posedge clk) disable iff (!rst_n)
      err_fatal |-> ($past(req_priv) && rsp_poison));
endmodule

// File: tb/test_poison_word_store.sv
module test_poison_word_store;
   localparam int DW = 32;
   localparam int CWB = 39;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0, req_priv = 1'b0;
   logic [3:0] req_addr = '0;
   logic [3:0] req_be = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [CWB-1:0] inj_flip = '0;
   logic rsp_valid, rsp_poison, err_recov, err_fatal, svc_pulse;
   logic [DW-1:0] rsp_rdata;
   logic [3:0] err_addr;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   poison_word_store #(.DATA_W(DW), .DEPTH(16)) i_poison_word_store (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
      .req_priv(req_priv), .inj_flip(inj_flip), .rsp_valid(rsp_valid),
      .rsp_rdata(rsp_rdata), .rsp_poison(rsp_poison), .err_recov(err_recov),
      .err_fatal(err_fatal), .err_addr(err_addr), .svc_pulse(svc_pulse));

   typedef struct packed {
      logic v; logic [31:0] d; logic p; logic rc; logic ft; logic sv;
      logic [3:0] ea; logic [7:0] rq;
   } exp_t;

   exp_t q[$];
   logic [31:0] mdata [16];
   int mst [16];   // 0 clean, 1 single fault, 2 double fault, 3 poisoned

   task automatic op(input bit wr, input int a, input logic [31:0] d,
                     input logic [3:0] be, input bit priv,
                     input logic [CWB-1:0] flip, input int nflip, input int rq);
      exp_t e;
      e = '0;
      e.rq = 8'(rq);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = 4'(a);
      req_wdata = d; req_be = be; req_priv = priv; inj_flip = flip;
      if (wr) begin
         logic [31:0] m;
         for (int b = 0; b < 4; b++) m[8*b +: 8] = be[b] ? d[8*b +: 8] : mdata[a][8*b +: 8];
         if (be == 4'hF) mst[a] = nflip;
         else if (mst[a] >= 2) begin e.sv = (mst[a] == 2); mst[a] = 3; end
         else mst[a] = nflip;
         mdata[a] = m;
      end else begin
         e.v = 1'b1;
         case (mst[a])
            0: e.d = mdata[a];
            1: begin e.d = mdata[a]; mst[a] = 0; end
            2: begin e.p = 1'b1; e.sv = 1'b1; mst[a] = 3; end
            default: begin
               e.p = 1'b1; e.rc = !priv; e.ft = priv; e.ea = 4'(a);
            end
         endcase
      end
      q.push_back(e);
   endtask

   task automatic idle();
      exp_t e;
      e = '0;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0; inj_flip = '0;
      q.push_back(e);
   endtask

   task automatic wrf(input int a, input logic [31:0] d, input logic [CWB-1:0] f, input int n, input int rq);
      op(1'b1, a, d, 4'hF, 1'b0, f, n, rq);
   endtask
   task automatic rd(input int a, input bit priv, input int rq);
      op(1'b0, a, '0, 4'h0, priv, '0, 0, rq);
   endtask

   always @(posedge clk) begin
      exp_t e;
      if (rst_n && q.size() != 0) begin
         e = q.pop_front();
         #2;
         checks++;
         if (rsp_valid !== e.v || (e.v && rsp_rdata !== e.d) || rsp_poison !== e.p ||
             err_recov !== e.rc || err_fatal !== e.ft || svc_pulse !== e.sv ||
             ((e.rc || e.ft) && err_addr !== e.ea)) begin
            errors++;
            $display("FAIL R%0d: got v=%b d=%h p=%b rc=%b ft=%b sv=%b ea=%h exp v=%b d=%h p=%b rc=%b ft=%b sv=%b ea=%h",
                     e.rq, rsp_valid, rsp_rdata, rsp_poison, err_recov, err_fatal, svc_pulse, err_addr,
                     e.v, e.d, e.p, e.rc, e.ft, e.sv, e.ea);
         end
      end
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got hung run, expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int k = 0; k < 16; k++) begin mdata[k] = '0; mst[k] = 0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      checks++;   // R1 reset state
      if (rsp_valid !== 1'b0 || rsp_poison !== 1'b0 || err_recov !== 1'b0 ||
          err_fatal !== 1'b0 || svc_pulse !== 1'b0 || rsp_rdata !== '0) begin
         errors++;
         $display("FAIL R1 reset: got v=%b p=%b rc=%b ft=%b sv=%b d=%h expected all zero",
                  rsp_valid, rsp_poison, err_recov, err_fatal, svc_pulse, rsp_rdata);
      end
      rst_n = 1'b1;

      // R1: clean store and read, privilege has no effect on clean words
      wrf(0, 32'hA5A5_0001, '0, 0, 1);
      rd(0, 1'b0, 1);
      wrf(1, 32'hFFFF_0000, '0, 0, 1);
      rd(1, 1'b1, 1);
      // R2: single faults in a data bit, a check bit and the overall bit
      wrf(2, 32'h1234_5678, 39'h1 << 5, 1, 2);
      rd(2, 1'b0, 2);
      rd(2, 1'b0, 2);
      wrf(3, 32'hDEAD_BEEF, 39'h1 << 33, 1, 2);
      rd(3, 1'b1, 2);
      wrf(4, 32'h0BAD_F00D, 39'h1 << 38, 1, 2);
      rd(4, 1'b0, 2);
      // R3/R4 detection, then R5 and R6 consumption
      wrf(5, 32'hCAFE_0005, 39'h3 << 10, 2, 3);
      rd(5, 1'b0, 3);
      rd(5, 1'b0, 5);
      rd(5, 1'b1, 6);
      wrf(6, 32'h6666_6666, 39'h3 << 20, 2, 3);
      rd(6, 1'b1, 3);
      rd(6, 1'b1, 6);
      // R7: full overwrite clears poison silently
      wrf(5, 32'h5555_AAAA, '0, 0, 7);
      rd(5, 1'b1, 7);
      // R8: partial write keeps poison; partial write onto a double fault poisons
      op(1'b1, 6, 32'h0000_00EE, 4'b0001, 1'b0, '0, 0, 8);
      rd(6, 1'b0, 8);
      wrf(7, 32'h7777_7777, 39'h5 << 2, 2, 8);
      op(1'b1, 7, 32'h0000_EE00, 4'b0010, 1'b0, '0, 0, 8);
      rd(7, 1'b0, 8);
      // R9: byte merge with clean and with corrected old content
      wrf(8, 32'h1122_3344, '0, 0, 9);
      op(1'b1, 8, 32'hAABB_CCDD, 4'b0101, 1'b0, '0, 0, 9);
      rd(8, 1'b0, 9);
      wrf(9, 32'h0F0F_0F0F, 39'h1 << 3, 1, 9);
      op(1'b1, 9, 32'hFF00_0000, 4'b1000, 1'b0, '0, 0, 9);
      rd(9, 1'b0, 9);
      // R4: back-to-back fresh poisonings pulse once each
      wrf(10, 32'hA0A0_A0A0, 39'h3 << 0, 2, 4);
      wrf(11, 32'hB1B1_B1B1, 39'h3 << 30, 2, 4);
      rd(10, 1'b0, 4);
      rd(11, 1'b1, 4);
      rd(10, 1'b1, 6);
      repeat (3) idle();
      wait (q.size() == 0);
      @(negedge clk);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule